// File: doc/BRIEF.md
# Per-Client DMA Flush and Hot Reset Controller

This block lets software quiesce any one of up to fifteen memory clients and then hold it in reset without losing work already handed to memory. Every client has a request/ready handshake toward the block and a matching valid/ready pair toward the memory side, plus a completion strobe returned from memory. A per-client allow bit gates new requests. A per-client counter tracks how many accepted transactions are still waiting for completion. A per-client active-low reset bit drives that client's hot-reset output.

The intended sequence is: clear the client's allow bit, poll its status word until it reads zero, then clear its reset bit. Releasing goes in the reverse order. A blocked request is stalled by holding ready low, and it is never dropped. Completions for transactions already accepted keep draining the counter while the client is blocked.

The register port is a single-cycle write strobe with a combinational read. Word offset 0 holds the allow bits, offset 1 holds the reset bits, and offsets 2 to 2+N-1 hold the status counts. In the two bit registers, client i uses bit i.

Top module: `mcflush_top`

## Requirements
- R1: After reset, the allow word and the reset word both read 0x7FFF. Every client_rst_n output is high, every status word reads 0, and cli_rdy equals mem_ready for every client.
- R2: A write to offset 0 with bit i clear blocks client i from the next cycle on: mem_valid[i] and cli_rdy[i] stay low while the bit is clear. Other clients are unaffected.
- R3: A request from a blocked client is not counted. Once offset 0 is written with bit i set again, the same held request is presented on mem_valid[i] and is accepted.
- R4: A request counts as accepted on a clock edge when cli_req, mem_ready and the allow bit are all high and the status count is below its maximum. The status word at offset 2+i rises by one per accepted request and falls by one per mem_done pulse. When both happen on the same edge, it is unchanged.
- R5: While a client is blocked, mem_done pulses still drain its status word, which reaches exactly 0 once all in-flight transactions have completed.
- R6: A mem_done pulse while the status count is 0 is ignored, and the count stays 0.
- R7: With the default 4-bit counter, the status saturates at 15. cli_rdy is low at 15, and the count never wraps to 0.
- R8: A write to offset 1 drives client_rst_n to the written low bits from the next cycle on, where a 0 means reset is asserted. The same value reads back at offset 1.
- R9: Write bits above bit 14 are discarded and read back as 0. Reads of unmapped offsets (17 and up) return 0.
- R10: Writes to the status offsets change neither the allow word, the reset word nor any status count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| csr_we | input | 1 | Register write strobe, one cycle per write |
| csr_addr | input | ADDR_W (5) | Register word offset |
| csr_wdata | input | DATA_W (32) | Register write data |
| csr_rdata | output | DATA_W (32) | Register read data, combinational from csr_addr |
| cli_req | input | N (15) | Per-client request valid |
| cli_rdy | output | N (15) | Per-client ready back to the client |
| mem_valid | output | N (15) | Per-client request toward memory |
| mem_ready | input | N (15) | Per-client readiness of memory |
| mem_done | input | N (15) | Per-client completion pulse from memory |
| client_rst_n | output | N (15) | Per-client active-low hot reset |

## Verification
The assertions take for granted that csr_we is a one-cycle strobe whose address and data are stable around the clock edge. They also assume that mem_done is a pulse tied to one edge, not a level that is sampled twice. They do not assume completions are matched to accepted requests, because the counter itself guards against underflow and overflow. The stimulus changes every input one time unit after a rising edge and samples one time unit later. It pulses mem_done only for one edge at a time, and it raises a stray completion only in the deliberate zero-count case.

// File: rtl/mcflush_pkg.sv
package mcflush_pkg;

    // word offsets of the register map
    localparam int unsigned OFF_ALLOW     = 0;
    localparam int unsigned OFF_HOTRST    = 1;
    localparam int unsigned OFF_STAT_BASE = 2;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_ALLOW,
        SEL_HOTRST,
        SEL_STAT
    } csr_sel_e;

endpackage

// File: rtl/mcflush_csr.sv
module mcflush_csr
    import mcflush_pkg::*;
#(
    parameter int N      = 15,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      csr_we,
    input  logic [ADDR_W-1:0]         csr_addr,
    input  logic [DATA_W-1:0]         csr_wdata,
    output logic [DATA_W-1:0]         csr_rdata,
    input  logic [N-1:0][CNT_W-1:0]   stat_cnt,
    output logic [N-1:0]              allow,
    output logic [N-1:0]              hot_rst_n
);

    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam logic [ADDR_W-1:0] A_ALLOW  = ADDR_W'(OFF_ALLOW);
    localparam logic [ADDR_W-1:0] A_HOTRST = ADDR_W'(OFF_HOTRST);
    localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(OFF_STAT_BASE);
    localparam logic [ADDR_W-1:0] A_END    = ADDR_W'(OFF_STAT_BASE + N);

    typedef struct packed {
        logic [N-1:0] allow;
        logic [N-1:0] rstn;
    } csr_state_t;

    csr_state_t        state_d, state_q;
    csr_sel_e          sel;
    logic [ADDR_W-1:0] stat_off;
    logic [IDX_W-1:0]  stat_idx;

    // address decode
    always_comb begin
        sel      = SEL_NONE;
        stat_off = csr_addr - A_STAT;
        stat_idx = stat_off[IDX_W-1:0];
        if (csr_addr == A_ALLOW) begin
            sel = SEL_ALLOW;
        end else if (csr_addr == A_HOTRST) begin
            sel = SEL_HOTRST;
        end else if (csr_addr >= A_STAT && csr_addr < A_END) begin
            sel = SEL_STAT;
        end
    end

    // next state and read data
    always_comb begin
        state_d = state_q;
        if (csr_we && sel == SEL_ALLOW) begin
            state_d.allow = csr_wdata[N-1:0];
        end
        if (csr_we && sel == SEL_HOTRST) begin
            state_d.rstn = csr_wdata[N-1:0];
        end

        unique case (sel)
            SEL_ALLOW:  csr_rdata = DATA_W'(state_q.allow);
            SEL_HOTRST: csr_rdata = DATA_W'(state_q.rstn);
            SEL_STAT:   csr_rdata = DATA_W'(stat_cnt[stat_idx]);
            default:    csr_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.allow <= '1;
            state_q.rstn  <= '1;
        end else begin
            state_q <= state_d;
        end
    end

    assign allow     = state_q.allow;
    assign hot_rst_n = state_q.rstn;

    // R8: reset outputs follow a write to the reset word one cycle later
    a_r8_hotrst_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_addr == A_HOTRST) |=> (hot_rst_n == $past(csr_wdata[N-1:0])));

    // R10: writes aimed at status words leave both control words alone
    a_r10_stat_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_addr >= A_STAT) |=> ($stable(allow) && $stable(hot_rst_n)));

endmodule

// File: rtl/mcflush_track.sv
module mcflush_track #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             allow,
    input  logic             cli_req,
    output logic             cli_rdy,
    output logic             mem_valid,
    input  logic             mem_ready,
    input  logic             mem_done,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } trk_state_t;

    trk_state_t state_d, state_q;
    logic       full, open_q, take, retire;

    always_comb begin
        full      = (state_q.count == CNT_MAX);
        open_q    = allow && !full;
        mem_valid = cli_req && open_q;
        cli_rdy   = open_q && mem_ready;
        take      = cli_req && cli_rdy;
        retire    = mem_done && (state_q.count != '0);

        state_d = state_q;
        unique case ({take, retire})
            2'b10:   state_d.count = state_q.count + CNT_ONE;
            2'b01:   state_d.count = state_q.count - CNT_ONE;
            default: state_d.count = state_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.count <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign count = state_q.count;

    // R4: the in-flight count moves by at most one per cycle
    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (count == $past(count) || count == $past(count) + CNT_ONE
                  || count == $past(count) - CNT_ONE));

    // R6: an idle counter never goes below zero
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |=> (count <= CNT_ONE));

    // R7: a saturated counter never wraps
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_MAX) |=> (count != '0));

endmodule

// File: rtl/mcflush_array.sv
module mcflush_array #(
    parameter int N     = 15,
    parameter int CNT_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N-1:0]            allow,
    input  logic [N-1:0]            cli_req,
    output logic [N-1:0]            cli_rdy,
    output logic [N-1:0]            mem_valid,
    input  logic [N-1:0]            mem_ready,
    input  logic [N-1:0]            mem_done,
    output logic [N-1:0][CNT_W-1:0] count
);

    for (genvar i = 0; i < N; i++) begin : g_client
        mcflush_track #(.CNT_W(CNT_W)) u_track (
            .clk       (clk),
            .rst_n     (rst_n),
            .allow     (allow[i]),
            .cli_req   (cli_req[i]),
            .cli_rdy   (cli_rdy[i]),
            .mem_valid (mem_valid[i]),
            .mem_ready (mem_ready[i]),
            .mem_done  (mem_done[i]),
            .count     (count[i])
        );
    end

endmodule

// File: rtl/mcflush_top.sv
module mcflush_top
    import mcflush_pkg::*;
#(
    parameter int N      = 15,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_we,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic [DATA_W-1:0] csr_wdata,
    output logic [DATA_W-1:0] csr_rdata,
    input  logic [N-1:0]      cli_req,
    output logic [N-1:0]      cli_rdy,
    output logic [N-1:0]      mem_valid,
    input  logic [N-1:0]      mem_ready,
    input  logic [N-1:0]      mem_done,
    output logic [N-1:0]      client_rst_n
);

    localparam logic [ADDR_W-1:0] A_ALLOW = ADDR_W'(OFF_ALLOW);

    logic [N-1:0]            allow;
    logic [N-1:0][CNT_W-1:0] count;

    mcflush_csr #(.N(N), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_we    (csr_we),
        .csr_addr  (csr_addr),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata),
        .stat_cnt  (count),
        .allow     (allow),
        .hot_rst_n (client_rst_n)
    );

    mcflush_array #(.N(N), .CNT_W(CNT_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .allow     (allow),
        .cli_req   (cli_req),
        .cli_rdy   (cli_rdy),
        .mem_valid (mem_valid),
        .mem_ready (mem_ready),
        .mem_done  (mem_done),
        .count     (count)
    );

    // R2: a cleared allow bit stops the client from the next cycle on
    for (genvar i = 0; i < N; i++) begin : g_chk
        a_r2_block_after_write: assert property (@(posedge clk) disable iff (!rst_n)
            (csr_we && csr_addr == A_ALLOW && !csr_wdata[i])
                |=> (!mem_valid[i] && !cli_rdy[i]));
    end

endmodule

// File: tb/mcflush_top_bench.sv
module mcflush_top_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int N = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic [4:0]  csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic [N-1:0] cli_req = '0;
    logic [N-1:0] cli_rdy;
    logic [N-1:0] mem_valid;
    logic [N-1:0] mem_ready = '1;
    logic [N-1:0] mem_done = '0;
    logic [N-1:0] client_rst_n;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    mcflush_top u_mcflush_top (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .cli_req(cli_req),
        .cli_rdy(cli_rdy), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_done(mem_done), .client_rst_n(client_rst_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // advance to one time unit past the next rising edge
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        tick();
        csr_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        csr_addr = a;
        #1;
        d = csr_rdata;
    endtask

    task automatic stat_is(input string req, input int c, input int exp);
        logic [31:0] v;
        rd(5'(2 + c), v);
        chk(req, v, 32'(exp));
    endtask

    task automatic t_reset();
        logic [31:0] v;
        int bad = 0;
        rd(5'd0, v); chk("R1 allow word", v, 32'h7FFF);
        rd(5'd1, v); chk("R1 reset word", v, 32'h7FFF);
        chk("R1 client_rst_n", 32'(client_rst_n), 32'h7FFF);
        for (int c = 0; c < N; c++) begin
            rd(5'(2 + c), v);
            if (v != 0) bad++;
        end
        chk("R1 nonzero status words", 32'(bad), 32'd0);
        chk("R1 cli_rdy", 32'(cli_rdy), 32'h7FFF);
    endtask

    task automatic t_count();
        cli_req[3] = 1'b1;
        tick(); tick(); tick();
        cli_req[3] = 1'b0;
        stat_is("R4 three accepted", 3, 3);
        mem_done[3] = 1'b1; tick(); mem_done[3] = 1'b0;
        stat_is("R4 one completion", 3, 2);
        cli_req[3] = 1'b1; mem_done[3] = 1'b1; tick();
        cli_req[3] = 1'b0; mem_done[3] = 1'b0;
        stat_is("R4 accept with completion", 3, 2);
        mem_ready[2] = 1'b0; cli_req[2] = 1'b1;
        #1 chk("R4 rdy follows mem_ready", 32'(cli_rdy[2]), 32'd0);
        tick(); tick();
        cli_req[2] = 1'b0; mem_ready[2] = 1'b1;
        stat_is("R4 not counted without mem_ready", 2, 0);
        mem_done[3] = 1'b1; tick(); tick(); mem_done[3] = 1'b0;
        stat_is("R4 drained", 3, 0);
    endtask

    task automatic t_block();
        cli_req[5] = 1'b1; tick(); tick(); cli_req[5] = 1'b0;
        wr(5'd0, 32'h7FFF & ~(32'd1 << 5));
        cli_req[5] = 1'b1; cli_req[4] = 1'b1;
        #1;
        chk("R2 blocked rdy", 32'(cli_rdy[5]), 32'd0);
        chk("R2 blocked valid", 32'(mem_valid[5]), 32'd0);
        chk("R2 neighbour open", 32'(cli_rdy[4]), 32'd1);
        cli_req[4] = 1'b0;
        tick(); tick(); tick();
        stat_is("R3 blocked not counted", 5, 2);
        mem_done[5] = 1'b1; tick(); tick(); mem_done[5] = 1'b0;
        stat_is("R5 drained while blocked", 5, 0);
        stat_is("R2 neighbour untouched", 4, 0);
        wr(5'd0, 32'h7FFF);
        chk("R3 held request presented", 32'(mem_valid[5]), 32'd1);
        tick();
        cli_req[5] = 1'b0;
        stat_is("R3 held request accepted", 5, 1);
        mem_done[5] = 1'b1; tick(); mem_done[5] = 1'b0;
    endtask

    task automatic t_zero_done();
        mem_done[0] = 1'b1; tick(); mem_done[0] = 1'b0;
        stat_is("R6 stray completion ignored", 0, 0);
        cli_req[0] = 1'b1; tick(); cli_req[0] = 1'b0;
        stat_is("R6 count after stray", 0, 1);
        mem_done[0] = 1'b1; tick(); mem_done[0] = 1'b0;
    endtask

    task automatic t_saturate();
        cli_req[7] = 1'b1;
        for (int k = 0; k < 20; k++) tick();
        stat_is("R7 saturated", 7, 15);
        chk("R7 rdy low at max", 32'(cli_rdy[7]), 32'd0);
        cli_req[7] = 1'b0; mem_done[7] = 1'b1; tick(); mem_done[7] = 1'b0;
        stat_is("R7 no wrap", 7, 14);
        mem_done[7] = 1'b1;
        for (int k = 0; k < 14; k++) tick();
        mem_done[7] = 1'b0;
        stat_is("R7 drained", 7, 0);
    endtask

    task automatic t_hot_reset();
        logic [31:0] v;
        wr(5'd1, 32'h7FFF & ~(32'd1 << 9));
        chk("R8 reset asserted", 32'(client_rst_n), 32'h7DFF);
        rd(5'd1, v); chk("R8 reset readback", v, 32'h7DFF);
        wr(5'd1, 32'h7FFF);
        chk("R8 reset released", 32'(client_rst_n), 32'h7FFF);
    endtask

    task automatic t_map();
        logic [31:0] v;
        wr(5'd0, 32'hFFFF_FFFF);
        rd(5'd0, v); chk("R9 upper bits dropped", v, 32'h7FFF);
        rd(5'd17, v); chk("R9 offset 17 reads zero", v, 32'd0);
        rd(5'd31, v); chk("R9 offset 31 reads zero", v, 32'd0);
        wr(5'd2, 32'h0);
        wr(5'd6, 32'h5);
        rd(5'd0, v); chk("R10 allow intact", v, 32'h7FFF);
        rd(5'd1, v); chk("R10 reset intact", v, 32'h7FFF);
        stat_is("R10 status intact", 4, 0);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_count();
        t_block();
        t_zero_done();
        t_saturate();
        t_hot_reset();
        t_map();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule